// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block holds four independent down-counting timer channels, 32 bits each, behind a simple register bus. The bus has a write strobe, a read strobe, a byte address and 32-bit data. Each channel is set up by software with a reload value and a control word. It then counts down by one per clock. When a count of zero is consumed, the channel sets its timeout flag, raises its interrupt line if that is allowed, reloads and carries on. The hardware is therefore always periodic. A one-shot event is built by software, which turns the channel off from its interrupt handler.

A block-wide disable bit in the module control word freezes every channel. It comes out of reset set, so nothing counts until software clears it. Any channel above channel 0 can be chained to the channel below it. It then steps only when that lower channel expires, so channels 0 and 1 together form a 64-bit counter. Reads are combinational while the read strobe is high and return zero otherwise.

Top module: `tick_timer_array`

## Requirements
- R1: After reset every register reads zero, except the module control word, which reads 0x2 (the disable bit set). All interrupt lines are low.
- R2: The module control word is at byte offset 0x000 and its bit 1 is the block-wide disable. The register group of channel n starts at 0x100 + 0x10·n and holds the reload value at +0x0, the current count at +0x4, control at +0x8 and the flag at +0xC. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is chain; the other control bits read zero. Any other offset, including one not aligned to a word, reads zero.
- R3: A running channel decrements once per clock. In the step after the step that reaches zero it sets flag bit 0 and reloads the reload value, so one period lasts reload + 1 cycles.
- R4: A write that takes the run bit from 0 to 1 copies the reload value into the count at that clock edge. While the run bit is 0, the count holds its value.
- R5: Writing the reload value while the channel runs leaves the current count and period alone. The new value is used from the next reload on.
- R6: While the block-wide disable bit is 1, no channel's count changes, except through a run-bit 0-to-1 load. Clearing the bit resumes counting from the held value.
- R7: Each channel's interrupt line equals its flag ANDed with its interrupt-enable bit.
- R8: Writing 1 to flag bit 0 clears the flag, and writing 0 has no effect. If a clear and an expiry fall on the same edge, the flag stays set.
- R9: A channel n > 0 with its chain bit set steps (and can expire) only on a cycle in which channel n−1 expires.
- R10: The chain bit of channel 0 is not stored: it reads 0, and channel 0 counts every cycle regardless of it.
- R11: The current-count register is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low or the offset is unmapped |
| irq | output | 4 | One interrupt line per channel |

## Verification
Two events can land on the same clock edge: a software flag clear and a hardware expiry. The bench runs a channel until its count reads zero. It then issues the write-one-to-clear so that it takes effect on exactly the edge where the channel expires. The flag must stay set and the count must show the reload value. A second overlap is also tested: in a chained pair, channel 0 expiring and channel 1 expiring on the same edge. The bench checks that channel 1's flag and reload appear only in the cycle after its step partner expires.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register selector inside one channel group (address bits [3:2]).
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  // Control word, bit 0 = run, bit 1 = interrupt enable, bit 2 = chain.
  typedef struct packed {
    logic chain;
    logic ie;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W       = 3;
  localparam int unsigned MOD_DIS_BIT  = 1;
  localparam int unsigned FLAG_BIT     = 0;
  localparam int unsigned CH_BASE      = 'h100;
  localparam int unsigned CH_STRIDE_SH = 4;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 12
) (
  input  logic [AW-1:0]     addr,
  output logic              mod_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_sel_e          reg_sel
);

  localparam int unsigned GW     = AW - CH_STRIDE_SH;
  localparam int unsigned GROUP0 = CH_BASE >> CH_STRIDE_SH;

  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign mod_hit = (addr == '0);
  assign reg_sel = reg_sel_e'(addr[3:2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i] = aligned && (addr[AW-1:CH_STRIDE_SH] == GW'(GROUP0 + i));
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter bit          HAS_CHAIN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  reg_sel_e      reg_sel,
  input  logic [DW-1:0] wdata,
  input  logic          mod_dis,
  input  logic          prev_expire,
  output logic          expire,
  output logic          irq,
  output logic [DW-1:0] rd_word
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] reload_q, reload_d;
  logic [DW-1:0] cnt_q, cnt_d;
  ctrl_t         ctrl_q, ctrl_d;
  logic          flag_q, flag_d;

  logic reload_we, ctrl_we, flag_clr;
  logic run_rise, chain_on, tick;

  // Write decode
  always_comb begin
    reload_we = wr_sel && (reg_sel == REG_RELOAD);
    ctrl_we   = wr_sel && (reg_sel == REG_CTRL);
    flag_clr  = wr_sel && (reg_sel == REG_FLAG) && wdata[FLAG_BIT];
    run_rise  = ctrl_we && wdata[0] && !ctrl_q.run;
  end

  // Step qualification: run, block enabled, and lower-channel expiry when chained
  always_comb begin
    chain_on = HAS_CHAIN && ctrl_q.chain;
    tick     = ctrl_q.run && !mod_dis && (!chain_on || prev_expire);
    expire   = tick && (cnt_q == '0);
  end

  // Next-state logic
  always_comb begin
    reload_d     = wdata;
    ctrl_d.run   = wdata[0];
    ctrl_d.ie    = wdata[1];
    ctrl_d.chain = HAS_CHAIN ? wdata[2] : 1'b0;
    flag_d       = expire | (flag_q & ~flag_clr);
    if (run_rise || expire) begin
      cnt_d = reload_q;
    end else if (tick) begin
      cnt_d = cnt_q - ONE;
    end else begin
      cnt_d = cnt_q;
    end
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_we) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_rise || tick) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q & ctrl_q.ie;

  // Read mux
  always_comb begin
    rd_word = '0;
    unique case (reg_sel)
      REG_RELOAD: rd_word = reload_q;
      REG_COUNT:  rd_word = cnt_q;
      REG_CTRL:   rd_word[CTRL_W-1:0] = ctrl_q;
      REG_FLAG:   rd_word[FLAG_BIT] = flag_q;
      default:    rd_word = '0;
    endcase
  end

  // Assertions
  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_q)));

  assert_run_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> (cnt_q == $past(reload_q)));

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !run_rise) |=> $stable(cnt_q));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_dis && !run_rise) |=> $stable(cnt_q));

  assert_irq_on_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.ie && !ctrl_we) |=> irq);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  assert_chain_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_on && !prev_expire && !run_rise) |=> $stable(cnt_q));

endmodule

// File: rtl/tick_timer_array.sv
module tick_timer_array
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NUM_CH-1:0] irq
);

  logic              mod_hit;
  logic [NUM_CH-1:0] ch_hit;
  reg_sel_e          reg_sel;
  logic              mod_dis_q;
  logic [NUM_CH-1:0] ch_expire;
  logic [DW-1:0]     ch_word [NUM_CH];

  tmr_decode #(
    .NUM_CH (NUM_CH),
    .AW     (AW)
  ) u_decode (
    .addr    (addr),
    .mod_hit (mod_hit),
    .ch_hit  (ch_hit),
    .reg_sel (reg_sel)
  );

  // Block-wide disable, set out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_dis_q <= 1'b1;
    end else if (wr_en && mod_hit) begin
      mod_dis_q <= wdata[MOD_DIS_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic prev_exp;
    if (i == 0) begin : g_first
      assign prev_exp = 1'b0;
    end else begin : g_next
      assign prev_exp = ch_expire[i-1];
    end

    tmr_channel #(
      .DW        (DW),
      .HAS_CHAIN (i != 0)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_sel      (wr_en && ch_hit[i]),
      .reg_sel     (reg_sel),
      .wdata       (wdata),
      .mod_dis     (mod_dis_q),
      .prev_expire (prev_exp),
      .expire      (ch_expire[i]),
      .irq         (irq[i]),
      .rd_word     (ch_word[i])
    );
  end

  // Read return
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (mod_hit) begin
        rdata[MOD_DIS_BIT] = mod_dis_q;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_hit[i]) begin
          rdata = rdata | ch_word[i];
        end
      end
    end
  end

  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mod_hit, ch_hit}));

  assert_mapped_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |-> (rdata == '0));

endmodule

// File: tb/test_tick_timer_array.sv
`timescale 1ns/1ps
module test_tick_timer_array;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  tick_timer_array i_tick_timer_array (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Vector: {write, req[3:0], addr[11:0], data[31:0]}; reads compare data.
  localparam int NV = 23;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 4'd1,  12'h000, 32'h0000_0002},  // R1 disable bit set
    {1'b0, 4'd1,  12'h100, 32'h0},          // R1
    {1'b0, 4'd1,  12'h134, 32'h0},          // R1
    {1'b0, 4'd1,  12'h128, 32'h0},          // R1
    {1'b0, 4'd1,  12'h13C, 32'h0},          // R1
    {1'b1, 4'd2,  12'h110, 32'hDEAD_BEEF},  // R2 ch1 reload
    {1'b0, 4'd2,  12'h110, 32'hDEAD_BEEF},  // R2
    {1'b1, 4'd2,  12'h118, 32'hFFFF_FFFF},  // R2 ctrl
    {1'b0, 4'd2,  12'h118, 32'h0000_0007},  // R2 only 3 bits
    {1'b0, 4'd4,  12'h114, 32'hDEAD_BEEF},  // R4 load on run rise
    {1'b1, 4'd11, 12'h114, 32'h1234_5678},  // R11 write count
    {1'b0, 4'd11, 12'h114, 32'hDEAD_BEEF},  // R11 ignored
    {1'b1, 4'd10, 12'h108, 32'h0000_0007},  // R10 chain on ch0
    {1'b0, 4'd10, 12'h108, 32'h0000_0003},  // R10 chain not kept
    {1'b0, 4'd2,  12'h140, 32'h0},          // R2 past last channel
    {1'b0, 4'd2,  12'h102, 32'h0},          // R2 unaligned
    {1'b0, 4'd2,  12'h004, 32'h0},          // R2 gap
    {1'b0, 4'd2,  12'h200, 32'h0},          // R2 gap
    {1'b1, 4'd8,  12'h11C, 32'h0000_0001},  // R8 clear with flag low
    {1'b0, 4'd8,  12'h11C, 32'h0},          // R8
    {1'b1, 4'd2,  12'h118, 32'h0},
    {1'b0, 4'd2,  12'h118, 32'h0},          // R2
    {1'b1, 4'd2,  12'h108, 32'h0}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  // Combinational read within the low phase; consumes no edge.
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic rd_chk(input int req, input string what,
                        input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    check(1, "irq after reset", {28'b0, irq}, 32'h0);  // R1

    // Table walk: map, reset values, read-only and ignored writes
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) begin
        wr(VEC[i][43:32], VEC[i][31:0]);
      end else begin
        rd_chk(int'(VEC[i][47:44]), $sformatf("vector %0d", i),
               VEC[i][43:32], VEC[i][31:0]);
      end
    end

    wr(12'h000, 32'h0);  // enable block

    // R3 / R7 / R8 on channel 2
    wr(12'h120, 32'd5);
    wr(12'h128, 32'h3);
    rd_chk(3, "load on start", 12'h124, 32'd5);
    check(7, "irq before expiry", {31'b0, irq[2]}, 32'h0);
    wait_cyc(2);
    rd_chk(3, "count after 2", 12'h124, 32'd3);
    wait_cyc(3);
    rd_chk(3, "count at zero", 12'h124, 32'd0);
    rd_chk(3, "flag before expiry", 12'h12C, 32'd0);
    wait_cyc(1);
    rd_chk(3, "reload after expiry", 12'h124, 32'd5);
    rd_chk(3, "flag at expiry", 12'h12C, 32'd1);
    check(7, "irq with ie", {31'b0, irq[2]}, 32'h1);
    wr(12'h128, 32'h1);
    check(7, "irq with ie off", {31'b0, irq[2]}, 32'h0);
    rd_chk(7, "flag kept ie off", 12'h12C, 32'd1);
    wr(12'h128, 32'h3);
    check(7, "irq ie back on", {31'b0, irq[2]}, 32'h1);
    wr(12'h12C, 32'h0);
    rd_chk(8, "write 0 no clear", 12'h12C, 32'd1);
    wr(12'h12C, 32'h1);
    rd_chk(8, "write 1 clears", 12'h12C, 32'd0);
    check(7, "irq after clear", {31'b0, irq[2]}, 32'h0);
    rd_chk(3, "count keeps running", 12'h124, 32'd1);
    wait_cyc(1);
    rd_chk(3, "count zero again", 12'h124, 32'd0);
    wr(12'h12C, 32'h1);  // clear lands on expiry edge
    rd_chk(8, "set wins over clear", 12'h12C, 32'd1);
    rd_chk(3, "reload on collision", 12'h124, 32'd5);
    wr(12'h128, 32'h0);

    // R5 / R4 / R6 on channel 3
    wr(12'h130, 32'd5);
    wr(12'h138, 32'h1);
    wait_cyc(1);
    wr(12'h130, 32'd2);
    rd_chk(5, "period not restarted", 12'h134, 32'd3);
    wait_cyc(3);
    rd_chk(5, "old period ends", 12'h134, 32'd0);
    wait_cyc(1);
    rd_chk(5, "new reload used", 12'h134, 32'd2);
    wr(12'h138, 32'h0);
    wr(12'h130, 32'd7);
    rd_chk(4, "stopped count", 12'h134, 32'd1);
    wait_cyc(3);
    rd_chk(4, "hold while stopped", 12'h134, 32'd1);
    wr(12'h138, 32'h1);
    rd_chk(4, "restart loads reload", 12'h134, 32'd7);
    wr(12'h000, 32'h2);
    rd_chk(6, "count at disable", 12'h134, 32'd6);
    wait_cyc(4);
    rd_chk(6, "frozen by disable", 12'h134, 32'd6);
    wr(12'h000, 32'h0);
    rd_chk(6, "no step on enable edge", 12'h134, 32'd6);
    wait_cyc(1);
    rd_chk(6, "resumes", 12'h134, 32'd5);
    wr(12'h138, 32'h0);

    // R9 chained pair, R10 channel 0 ignores chain
    wr(12'h110, 32'd1);
    wr(12'h118, 32'h5);
    wr(12'h100, 32'd2);
    wr(12'h108, 32'h5);
    rd_chk(9, "upper idle before lower runs", 12'h114, 32'd1);
    wait_cyc(3);
    rd_chk(10, "ch0 free-running", 12'h104, 32'd2);
    rd_chk(9, "upper stepped once", 12'h114, 32'd0);
    rd_chk(9, "upper flag low", 12'h11C, 32'd0);
    wait_cyc(2);
    rd_chk(9, "upper waits", 12'h114, 32'd0);
    wait_cyc(1);
    rd_chk(9, "upper reload", 12'h114, 32'd1);
    rd_chk(9, "upper flag on joint expiry", 12'h11C, 32'd1);
    wr(12'h108, 32'h0);
    wr(12'h118, 32'h0);

    // R1 reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
    rd_chk(1, "disable after reset", 12'h000, 32'h2);
    rd_chk(1, "count after reset", 12'h114, 32'h0);
    rd_chk(1, "reload after reset", 12'h130, 32'h0);
    rd_chk(1, "flag after reset", 12'h11C, 32'h0);
    check(1, "irq after reset", {28'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule